// File: doc/BRIEF.md
# Record-Gated Burst Read Buffer

This block is a circular buffer in one clock domain. It accepts one data word on each write strobe. Words are not read out as soon as they arrive. Reading waits until a complete record is stored, and a record ends with the all-zero word. The block counts how many of these terminators are stored and not yet consumed.

While at least one record is pending, the block enters burst mode and reads words out one at a time, in write order. Reads are spaced a fixed number of clock cycles apart by an internal cycle counter. Each read shows as a one-cycle valid pulse with registered data.

The downstream consumer pulses `done_i` each time it has taken in a terminator word. Each such pulse retires one pending record. The burst ends once that pulse leaves no record pending. Writes stay accepted throughout a burst.

Top module: `rec_burst_fifo`

## Requirements
- R1: While `rst_ni` is low, and after it is released with no writes, `rd_valid_o` is 0, `busy_o` is 0 and `rec_pend_o` is 0.
- R2: The write and read positions each advance by one per access and wrap from address DEPTH-1 to 0, so more than DEPTH words written over several bursts are read back in write order.
- R3: A write whose data is all zeros (8'h00) raises `rec_pend_o` by one on the write edge. A write of any nonzero word leaves `rec_pend_o` unchanged and starts no read. `rec_pend_o` never changes by more than one per cycle.
- R4: When idle with `rec_pend_o` nonzero, `busy_o` rises on the next edge, and the first read pulse follows on the edge after that.
- R5: Within a burst, successive `rd_valid_o` pulses are exactly GAP cycles apart (GAP = 10 by default).
- R6: Each `rd_valid_o` is a one-cycle pulse, and `rd_data_o` then holds the oldest word not yet read. No read pulse occurs unless `busy_o` was 1 in the cycle before.
- R7: A `done_i` pulse while `rec_pend_o` is nonzero lowers `rec_pend_o` by one.
- R8: If `rec_pend_o` is still nonzero after a `done_i`, `busy_o` stays 1 and reads continue. If it becomes zero, `busy_o` falls on that same edge and no further read pulse occurs.
- R9: A zero-word write and a `done_i` pulse on the same edge, with `rec_pend_o` nonzero, leave `rec_pend_o` unchanged.
- R10: Writes during a burst are stored, and those words are read later in write order.
- R11: A `done_i` pulse while `rec_pend_o` is 0 is ignored: `rec_pend_o` stays 0 and `busy_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one word per cycle high |
| wr_data_i | input | DW (8) | Word to store; 8'h00 ends a record |
| done_i | input | 1 | Consumer pulse: a terminator word was taken |
| rd_valid_o | output | 1 | One-cycle pulse per word read out |
| rd_data_o | output | DW (8) | Registered word read out |
| rec_pend_o | output | $clog2(DEPTH+1) (6) | Count of pending records |
| busy_o | output | 1 | Burst in progress |

## Verification
A corrupted read position or a skipped stored word shows up at the first read pulse that follows, as a word out of write order against the scoreboard. A pacing counter stuck or loaded with the wrong value moves the second pulse of a burst away from the ten-cycle spacing, so it is caught within one read interval. A pending count that drifts shows at `rec_pend_o` on the very next sample. It also appears as a burst that fails to stop after the consumer's last acknowledgement, or that never starts, and the bench sees this within two cycles as extra or missing read pulses.

// File: rtl/rbf_pkg.sv
package rbf_pkg;
  typedef enum logic {
    BURST_IDLE = 1'b0,
    BURST_RUN  = 1'b1
  } burst_st_e;
endpackage

// File: rtl/rbf_wrap_ptr.sv
module rbf_wrap_ptr #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  output logic [AW-1:0] ptr_o
);
  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            ptr_q <= '0;
    else if (inc_i && ptr_q == AW'(DEPTH-1)) ptr_q <= '0;
    else if (inc_i)                         ptr_q <= ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;

  AST_PTR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && ptr_q == AW'(DEPTH-1)) |=> (ptr_q == '0)); // R2
endmodule

// File: rtl/rbf_store.sv
module rbf_store #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= mem_q[rd_addr_i];
    end
  end
endmodule

// File: rtl/rbf_pace.sv
module rbf_pace #(
  parameter int GAP = 10,
  localparam int GW = $clog2(GAP)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic fire_o
);
  logic [GW-1:0] cnt_q;

  // fire immediately on entry, then every GAP cycles while running
  assign fire_o = run_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (fire_o) cnt_q <= GW'(GAP-1);
    else             cnt_q <= cnt_q - 1'b1;
  end

  AST_FIRE_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o); // R5
endmodule

// File: rtl/rbf_rec_ctrl.sv
module rbf_rec_ctrl
  import rbf_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW   = $clog2(DEPTH+1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          delim_wr_i,
  input  logic          done_i,
  output logic [CW-1:0] pend_o,
  output logic          busy_o,
  output logic          run_o
);
  burst_st_e     st_q, st_d;
  logic [CW-1:0] pend_q, pend_d;
  logic          dec, stop;

  assign dec    = done_i && (pend_q != '0);
  assign pend_d = pend_q + CW'(delim_wr_i) - CW'(dec);
  assign stop   = (st_q == BURST_RUN) && done_i && (pend_d == '0);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      BURST_IDLE: if (pend_q != '0) st_d = BURST_RUN;
      BURST_RUN:  if (stop)         st_d = BURST_IDLE;
      default:                      st_d = BURST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= BURST_IDLE;
      pend_q <= '0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
  assign busy_o = (st_q == BURST_RUN);
  // no read on the edge that ends the burst
  assign run_o  = busy_o && !stop;

  AST_PEND_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q != $past(pend_q)) |-> (pend_q == $past(pend_q) + 1'b1 || pend_q == $past(pend_q) - 1'b1)); // R3
  AST_BURST_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && pend_q != '0) |=> busy_o); // R4
  AST_DONE_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !delim_wr_i && pend_q != '0) |=> (pend_q == $past(pend_q) - 1'b1)); // R7
  AST_BURST_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && done_i && !delim_wr_i && pend_q == CW'(1)) |=> !busy_o); // R8
  AST_HOLD_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (delim_wr_i && done_i && pend_q != '0) |=> $stable(pend_q)); // R9
  AST_DONE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !delim_wr_i && pend_q == '0) |=> (pend_q == '0)); // R11
endmodule

// File: rtl/rec_burst_fifo.sv
module rec_burst_fifo #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int GAP   = 10,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH+1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          done_i,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o,
  output logic [CW-1:0] rec_pend_o,
  output logic          busy_o
);
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          delim_wr, run, fire;

  assign delim_wr = wr_en_i && (wr_data_i == '0);

  rbf_wrap_ptr #(.DEPTH(DEPTH)) i_wr_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(wr_en_i), .ptr_o(wr_ptr));

  rbf_wrap_ptr #(.DEPTH(DEPTH)) i_rd_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(fire), .ptr_o(rd_ptr));

  rbf_rec_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .delim_wr_i(delim_wr), .done_i(done_i),
    .pend_o(rec_pend_o), .busy_o(busy_o), .run_o(run));

  rbf_pace #(.GAP(GAP)) i_pace (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .fire_o(fire));

  rbf_store #(.DEPTH(DEPTH), .DW(DW)) i_store (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_ptr), .wr_data_i(wr_data_i),
    .rd_en_i(fire), .rd_addr_i(rd_ptr),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o));

  AST_READ_IN_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(busy_o)); // R6
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o); // R6
endmodule

// File: tb/test_rec_burst_fifo.sv
module test_rec_burst_fifo;
  localparam int DW = 8;
  localparam int CW = 6;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [DW-1:0] wr_data_i = '0;
  logic          done_mon = 1'b0, done_man = 1'b0;
  logic          done_i;
  logic          rd_valid_o;
  logic [DW-1:0] rd_data_o;
  logic [CW-1:0] rec_pend_o;
  logic          busy_o;

  int n_tests = 0, n_fail = 0, done_cnt = 0;
  int cyc = 0, last_rd = -1;
  bit gap_broken = 1'b1, finished = 1'b0;
  logic [DW-1:0] exp_q[$];

  assign done_i = done_mon | done_man;

  always #10 clk_i = ~clk_i;  // 50 MHz

  rec_burst_fifo i_rec_burst_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .done_i(done_i), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .rec_pend_o(rec_pend_o), .busy_o(busy_o));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_word(input logic [DW-1:0] d);
    wr_en_i   = 1'b1;
    wr_data_i = d;
    exp_q.push_back(d);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 600; i++) begin
      if (!busy_o && rec_pend_o == 0) break;
      @(negedge clk_i);
    end
    check(!busy_o && rec_pend_o == 0, "R8 idle after last done", int'(busy_o), 0);
  endtask

  // monitor: scoreboard, spacing, consumer acknowledge
  always @(negedge clk_i) begin
    cyc++;
    done_mon = 1'b0;
    if (!busy_o) gap_broken = 1'b1;
    if (rd_valid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 read with nothing expected", int'(rd_data_o), -1);
      end else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        check(rd_data_o == e, "R6/R2/R10 read order", int'(rd_data_o), int'(e));
      end
      if (!gap_broken)
        check(cyc - last_rd == 10, "R5 read spacing", cyc - last_rd, 10);
      last_rd = cyc;
      gap_broken = 1'b0;
      if (rd_data_o == '0) begin
        done_mon = 1'b1;
        done_cnt++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset
    repeat (3) @(negedge clk_i);
    check(rd_valid_o == 0 && busy_o == 0 && rec_pend_o == 0, "R1 in reset", int'(busy_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check(rd_valid_o == 0, "R1 valid low", int'(rd_valid_o), 0);
    check(busy_o == 0 && rec_pend_o == 0, "R1 idle", int'(rec_pend_o), 0);

    // R3 nonzero words do not open a record
    write_word(8'h11); write_word(8'h22); write_word(8'h33);
    repeat (20) @(negedge clk_i);
    check(rec_pend_o == 0, "R3 nonzero no record", int'(rec_pend_o), 0);
    check(busy_o == 0, "R3 no burst", int'(busy_o), 0);

    // R3/R4 terminator opens burst with fixed latency
    write_word(8'h00);
    check(rec_pend_o == 1, "R3 pend after zero", int'(rec_pend_o), 1);
    check(busy_o == 0, "R4 busy not yet", int'(busy_o), 0);
    @(negedge clk_i);
    check(busy_o == 1, "R4 busy rises", int'(busy_o), 1);
    check(rd_valid_o == 0, "R4 no read yet", int'(rd_valid_o), 0);
    @(negedge clk_i);
    check(rd_valid_o == 1, "R4 first read", int'(rd_valid_o), 1);
    wait_idle();
    check(rec_pend_o == 0, "R7 pend retired", int'(rec_pend_o), 0);

    // R8/R10 second record written during burst
    write_word(8'hA1); write_word(8'h00);
    write_word(8'hB2); write_word(8'hC3); write_word(8'h00);
    check(rec_pend_o == 2, "R3 two records", int'(rec_pend_o), 2);
    begin
      int tgt;
      tgt = done_cnt + 1;
      for (int i = 0; i < 300 && done_cnt < tgt; i++) @(negedge clk_i);
    end
    @(negedge clk_i);
    check(rec_pend_o == 1, "R7 one retired", int'(rec_pend_o), 1);
    check(busy_o == 1, "R8 burst continues", int'(busy_o), 1);
    wait_idle();

    // R9 terminator written on the same edge as done
    write_word(8'h5A); write_word(8'h00);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk_i);
      if (rd_valid_o && rd_data_o == 8'h00) break;
    end
    wr_en_i = 1'b1; wr_data_i = 8'h00; exp_q.push_back(8'h00);
    @(negedge clk_i);
    wr_en_i = 1'b0;
    check(rec_pend_o == 1, "R9 pend holds", int'(rec_pend_o), 1);
    check(busy_o == 1, "R8 busy holds", int'(busy_o), 1);
    wait_idle();

    // R11 stray done while idle
    done_man = 1'b1;
    @(negedge clk_i);
    done_man = 1'b0;
    check(rec_pend_o == 0, "R11 pend stays 0", int'(rec_pend_o), 0);
    repeat (3) @(negedge clk_i);
    check(busy_o == 0, "R11 no burst", int'(busy_o), 0);

    // R2 wrap across many records
    for (int r = 0; r < 6; r++) begin
      for (int k = 0; k < 6; k++) write_word(DW'(8'h40 + r*8 + k + 1));
      write_word(8'h00);
      wait_idle();
    end
    check(exp_q.size() == 0, "R2 all words read", exp_q.size(), 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule